// File: doc/BRIEF.md
# Response Ring Interrupt Status Logic

This block sits on the response path of an audio link controller. Codec responses come in from the link decoder and land in a small internal FIFO. A DMA engine drains that FIFO towards a ring buffer in memory. Each hand-off to the DMA counts as one delivery. The block tracks three events:

- **Response interrupt condition.** This fires when the deliveries reach a programmable threshold. It also fires when a frame closes with an empty response slot on every serial data input, whichever of the two happens first.
- **Overrun.** A response arrives while the FIFO has no room.
- **Interrupt request.** This is built from the latched status bits and two enable inputs.

Software sees one 8-bit status byte and clears it by writing ones. The status latches whether or not the interrupt is enabled. An overrun response is thrown away, but it is still recorded in the status byte. The link decoder, the DMA memory writes and the register bus are outside the block. They appear only as valid/ready pairs and single-cycle strobes.

Top module: `rsp_ring_status`

## Requirements
- R1: After synchronous reset `sts_o` is 8'h00, `irq_o` is 0 and `dma_valid_o` is 0. Bits 7:3 and bit 1 of `sts_o` read as zero at all times.
- R2: The FIFO holds up to DEPTH responses. `dma_valid_o` is high whenever it is non-empty. Responses reach `dma_data_o` in arrival order, and each one is handed over exactly once, on a cycle with both `dma_valid_o` and `dma_ready_i` high.
- R3: A response offered (`rsp_valid_i`) while the FIFO already holds DEPTH entries is discarded. That response sets status bit 2 (overrun) on the next clock edge.
- R4: Status bit 0 is set on the edge at which the N-th delivery since the last restart completes. N is `thresh_i`, and a value of 0 means 256.
- R5: `frame_end_i` high with every bit of `slot_empty_i` set also sets bit 0. If any bit of `slot_empty_i` is clear, it does not.
- R6: Whenever bit 0 is set, by either cause, the delivery count restarts from zero.
- R7: Both status bits latch their events even while `rint_en_i` or `ovr_en_i` is low.
- R8: A write (`sts_wr_i`) clears each status bit whose position in `sts_wdata_i` holds a 1. Positions holding 0 leave their bit unchanged.
- R9: When a hardware set and a software clear target the same bit in the same cycle, the bit stays set.
- R10: `irq_o` is registered. One cycle after the status or enables change, it equals (bit 0 AND `rint_en_i`) OR (bit 2 AND `ovr_en_i`). It stays high until the causing bits are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rsp_valid_i | input | 1 | A codec response is offered this cycle |
| rsp_data_i | input | DW | Response payload |
| dma_ready_i | input | 1 | DMA takes the FIFO head this cycle |
| dma_valid_o | output | 1 | FIFO holds at least one response |
| dma_data_o | output | DW | FIFO head response |
| frame_end_i | input | 1 | Strobe marking the close of a link frame |
| slot_empty_i | input | NUM_IN | Per-input empty response slot flags for the closing frame |
| thresh_i | input | CNT_W | Delivery threshold N (0 means 2^CNT_W) |
| rint_en_i | input | 1 | Response interrupt enable |
| ovr_en_i | input | 1 | Overrun interrupt enable |
| sts_wr_i | input | 1 | Status write strobe |
| sts_wdata_i | input | 8 | Write-one-to-clear data |
| sts_o | output | 8 | Status byte: bit 2 overrun, bit 0 response interrupt |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is a collision: an overrun set landing in the same cycle as a software clear of that same bit. The stimulus holds `dma_ready_i` low until the FIFO is full, then drives a response and a write of 8'h04 in one cycle. The same approach puts an all-empty frame end beside a write of 8'h01. The bench checks the drop rule by releasing the DMA afterwards. A scoreboard confirms that exactly the DEPTH accepted responses come out, in order, and none of the discarded ones.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
  localparam int STS_W    = 8;
  localparam int STS_RINT = 0;  // response interrupt status position
  localparam int STS_OVR  = 2;  // overrun status position
endpackage

// File: rtl/rsp_fifo.sv
module rsp_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic          full,
  output logic [AW:0]   count
);
  localparam logic [AW:0]   FULL_CNT = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LAST     = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push, pop;

  assign empty = (count == '0);
  assign full  = (count == FULL_CNT);
  assign push  = wr_en && !full;
  assign pop   = rd_en && !empty;
  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rsp_count.sv
module rsp_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             deliver,
  input  logic             restart,
  input  logic [CNT_W-1:0] thresh,
  output logic             hit
);
  localparam logic [CNT_W:0] MAX_N = {1'b1, {CNT_W{1'b0}}};

  logic [CNT_W:0] cnt;
  logic [CNT_W:0] n_eff;

  assign n_eff = (thresh == '0) ? MAX_N : {1'b0, thresh};
  assign hit   = deliver && ((cnt + 1'b1) == n_eff);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (deliver)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rsp_sts.sv
module rsp_sts
  import rsp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             set_rint,
  input  logic             set_ovr,
  input  logic             wr,
  input  logic [STS_W-1:0] wdata,
  input  logic             rint_en,
  input  logic             ovr_en,
  output logic [STS_W-1:0] sts,
  output logic             irq
);
  logic rint_q, ovr_q, irq_q;
  logic clr_rint, clr_ovr;

  assign clr_rint = wr && wdata[STS_RINT];
  assign clr_ovr  = wr && wdata[STS_OVR];

  always_ff @(posedge clk) begin
    if (rst) begin
      rint_q <= 1'b0;
      ovr_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      rint_q <= set_rint || (rint_q && !clr_rint);
      ovr_q  <= set_ovr  || (ovr_q  && !clr_ovr);
      irq_q  <= (rint_q && rint_en) || (ovr_q && ovr_en);
    end
  end

  always_comb begin
    sts           = '0;
    sts[STS_RINT] = rint_q;
    sts[STS_OVR]  = ovr_q;
  end

  assign irq = irq_q;
endmodule

// File: rtl/rsp_ring_status.sv
module rsp_ring_status
  import rsp_pkg::*;
#(
  parameter int DW     = 16,
  parameter int DEPTH  = 8,
  parameter int NUM_IN = 3,
  parameter int CNT_W  = 8,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rsp_valid_i,
  input  logic [DW-1:0]     rsp_data_i,
  input  logic              dma_ready_i,
  output logic              dma_valid_o,
  output logic [DW-1:0]     dma_data_o,
  input  logic              frame_end_i,
  input  logic [NUM_IN-1:0] slot_empty_i,
  input  logic [CNT_W-1:0]  thresh_i,
  input  logic              rint_en_i,
  input  logic              ovr_en_i,
  input  logic              sts_wr_i,
  input  logic [STS_W-1:0]  sts_wdata_i,
  output logic [STS_W-1:0]  sts_o,
  output logic              irq_o
);
  logic          fifo_empty, fifo_full;
  logic [AW:0]   fifo_cnt;
  logic          deliver, thr_hit, empty_frame, set_rint, set_ovr;

  rsp_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (rsp_valid_i),
    .wr_data (rsp_data_i),
    .rd_en   (dma_ready_i),
    .rd_data (dma_data_o),
    .empty   (fifo_empty),
    .full    (fifo_full),
    .count   (fifo_cnt)
  );

  assign dma_valid_o = !fifo_empty;
  assign deliver     = dma_valid_o && dma_ready_i;
  assign empty_frame = frame_end_i && (&slot_empty_i);
  assign set_rint    = thr_hit || empty_frame;
  assign set_ovr     = rsp_valid_i && fifo_full;

  rsp_count #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .deliver (deliver),
    .restart (set_rint),
    .thresh  (thresh_i),
    .hit     (thr_hit)
  );

  rsp_sts u_sts (
    .clk      (clk),
    .rst      (rst),
    .set_rint (set_rint),
    .set_ovr  (set_ovr),
    .wr       (sts_wr_i),
    .wdata    (sts_wdata_i),
    .rint_en  (rint_en_i),
    .ovr_en   (ovr_en_i),
    .sts      (sts_o),
    .irq      (irq_o)
  );
endmodule

// File: rtl/rsp_ring_status_chk.sv
module rsp_ring_status_chk #(
  parameter int DEPTH  = 8,
  parameter int NUM_IN = 3,
  parameter int CW     = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              rsp_valid_i,
  input logic              dma_ready_i,
  input logic              frame_end_i,
  input logic [NUM_IN-1:0] slot_empty_i,
  input logic              rint_en_i,
  input logic              ovr_en_i,
  input logic              sts_wr_i,
  input logic [7:0]        sts_wdata_i,
  input logic [7:0]        sts_o,
  input logic              irq_o,
  input logic              fifo_full,
  input logic [CW-1:0]     fifo_cnt
);
  p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (sts_o[7:3] == 5'd0) && !sts_o[1]);

  p_fifo_bound_r2: assert property (@(posedge clk) disable iff (rst)
    fifo_cnt <= CW'(DEPTH));

  p_ovr_set_r3: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_i && fifo_full |=> sts_o[2]);

  p_drop_r3: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_i && fifo_full && !dma_ready_i |=> fifo_cnt == $past(fifo_cnt));

  p_empty_frame_r5: assert property (@(posedge clk) disable iff (rst)
    frame_end_i && (&slot_empty_i) |=> sts_o[0]);

  p_hold_rint_r8: assert property (@(posedge clk) disable iff (rst)
    sts_o[0] && !(sts_wr_i && sts_wdata_i[0]) |=> sts_o[0]);

  p_clear_ovr_r8: assert property (@(posedge clk) disable iff (rst)
    sts_wr_i && sts_wdata_i[2] && !(rsp_valid_i && fifo_full) |=> !sts_o[2]);

  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_i && fifo_full && sts_wr_i && sts_wdata_i[2] |=> sts_o[2]);

  p_irq_on_r10: assert property (@(posedge clk) disable iff (rst)
    (sts_o[0] && rint_en_i) || (sts_o[2] && ovr_en_i) |=> irq_o);

  p_irq_off_r10: assert property (@(posedge clk) disable iff (rst)
    !sts_o[0] && !sts_o[2] |=> !irq_o);
endmodule

bind rsp_ring_status rsp_ring_status_chk #(
  .DEPTH(DEPTH), .NUM_IN(NUM_IN), .CW(AW+1)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .rsp_valid_i  (rsp_valid_i),
  .dma_ready_i  (dma_ready_i),
  .frame_end_i  (frame_end_i),
  .slot_empty_i (slot_empty_i),
  .rint_en_i    (rint_en_i),
  .ovr_en_i     (ovr_en_i),
  .sts_wr_i     (sts_wr_i),
  .sts_wdata_i  (sts_wdata_i),
  .sts_o        (sts_o),
  .irq_o        (irq_o),
  .fifo_full    (fifo_full),
  .fifo_cnt     (fifo_cnt)
);

// File: tb/tb_rsp_ring_status.sv
`timescale 1ns/1ps
module tb_rsp_ring_status;
  localparam int DW = 16, DEPTH = 8, NIN = 3, CW = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1;
  logic rsp_valid = 0, dma_ready = 1, frame_end = 0, rint_en = 0, ovr_en = 0, sts_wr = 0;
  logic [DW-1:0]  rsp_data = '0;
  logic [NIN-1:0] slot_empty = '0;
  logic [CW-1:0]  thresh = '0;
  logic [7:0]     sts_wdata = '0;
  logic           dma_valid, irq;
  logic [DW-1:0]  dma_data;
  logic [7:0]     sts;

  rsp_ring_status #(.DW(DW), .DEPTH(DEPTH), .NUM_IN(NIN), .CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .rsp_valid_i(rsp_valid), .rsp_data_i(rsp_data),
    .dma_ready_i(dma_ready), .dma_valid_o(dma_valid), .dma_data_o(dma_data),
    .frame_end_i(frame_end), .slot_empty_i(slot_empty), .thresh_i(thresh),
    .rint_en_i(rint_en), .ovr_en_i(ovr_en), .sts_wr_i(sts_wr),
    .sts_wdata_i(sts_wdata), .sts_o(sts), .irq_o(irq));

  int checks = 0, fails = 0;
  logic [DW-1:0] exp_q [$];
  logic [DW-1:0] seq = 16'h0100;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // driver: offers one response, records it in the scoreboard if it should be kept
  task automatic send(bit keep);
    rsp_valid = 1; rsp_data = seq;
    if (keep) exp_q.push_back(seq);
    seq++;
    cyc(1);
    rsp_valid = 0;
  endtask

  task automatic frame(logic [NIN-1:0] e);
    frame_end = 1; slot_empty = e;
    cyc(1);
    frame_end = 0; slot_empty = '0;
  endtask

  task automatic wr(logic [7:0] d);
    sts_wr = 1; sts_wdata = d;
    cyc(1);
    sts_wr = 0; sts_wdata = '0;
  endtask

  // monitor: compares every delivered response against the scoreboard (R2)
  always @(negedge clk) begin
    if (!rst && dma_valid && dma_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R2 unexpected delivery actual=%0h expected=none", dma_data);
      end else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        if (dma_data !== e) begin
          fails++;
          $display("FAIL R2 order actual=%0h expected=%0h", dma_data, e);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    cyc(3);
    rst = 0;
    @(negedge clk);
    chk("R1 sts reset", sts, 8'h00);
    chk("R1 irq reset", irq, 0);
    chk("R1 dma_valid reset", dma_valid, 0);

    // R4: threshold 3
    thresh = 8'd3; rint_en = 1;
    cyc(1);
    send(1); send(1); cyc(3); @(negedge clk);
    chk("R4 below N", sts[0], 0);
    send(1); cyc(2); @(negedge clk);
    chk("R4 at N", sts[0], 1);
    chk("R10 irq rint", irq, 1);
    cyc(1); wr(8'h01); @(negedge clk);
    chk("R8 clear bit0", sts[0], 0);
    cyc(1); @(negedge clk);
    chk("R10 irq drops", irq, 0);

    // R6 / R5
    cyc(1); send(1); send(1); cyc(3); @(negedge clk);
    chk("R6 restart after hit", sts[0], 0);
    cyc(1); frame(3'b011); @(negedge clk);
    chk("R5 partial frame", sts[0], 0);
    cyc(1); frame(3'b111); @(negedge clk);
    chk("R5 all empty frame", sts[0], 1);
    cyc(1); wr(8'h01);
    send(1); send(1); cyc(3); @(negedge clk);
    chk("R6 restart after frame", sts[0], 0);
    send(1); cyc(2); @(negedge clk);
    chk("R4 count resumes", sts[0], 1);

    // R7: enable off
    cyc(1); wr(8'h01); rint_en = 0;
    frame(3'b111); cyc(1); @(negedge clk);
    chk("R7 bit0 without enable", sts[0], 1);
    chk("R10 irq masked", irq, 0);

    // R8: zero bits and other bits have no effect
    cyc(1); wr(8'h00); @(negedge clk);
    chk("R8 write zero", sts, 8'h01);
    cyc(1); wr(8'h04); @(negedge clk);
    chk("R8 other bit", sts, 8'h01);
    cyc(1); rint_en = 1; cyc(1); @(negedge clk);
    chk("R10 enable raises irq", irq, 1);

    // R9 on bit0
    cyc(1);
    frame_end = 1; slot_empty = 3'b111; sts_wr = 1; sts_wdata = 8'h01;
    cyc(1);
    frame_end = 0; slot_empty = '0; sts_wr = 0; sts_wdata = '0;
    @(negedge clk);
    chk("R9 bit0 set wins", sts[0], 1);
    cyc(1); wr(8'h01); rint_en = 0;

    // R3 overrun with DMA stalled; threshold 0 means 256
    thresh = 8'd0; dma_ready = 0; ovr_en = 1;
    for (int i = 0; i < DEPTH; i++) send(1);
    @(negedge clk);
    chk("R3 no overrun at fill", sts[2], 0);
    chk("R2 valid when full", dma_valid, 1);
    cyc(1); send(0); send(0); @(negedge clk);
    chk("R3 overrun set", sts[2], 1);
    cyc(1); @(negedge clk);
    chk("R10 irq ovr", irq, 1);

    // R9 on bit2: overrun and clear together
    cyc(1);
    rsp_valid = 1; rsp_data = seq; seq++; sts_wr = 1; sts_wdata = 8'h04;
    cyc(1);
    rsp_valid = 0; sts_wr = 0; sts_wdata = '0;
    @(negedge clk);
    chk("R9 bit2 set wins", sts[2], 1);
    cyc(1); wr(8'h04); @(negedge clk);
    chk("R8 clear bit2", sts[2], 0);

    // R7 overrun without enable
    cyc(1); ovr_en = 0; send(0); cyc(1); @(negedge clk);
    chk("R7 bit2 without enable", sts[2], 1);
    chk("R10 irq masked ovr", irq, 0);
    cyc(1); wr(8'h04);

    // drain: only the DEPTH accepted responses come out
    dma_ready = 1;
    cyc(DEPTH + 4); @(negedge clk);
    chk("R3 dropped never delivered", exp_q.size(), 0);
    chk("R2 empty after drain", dma_valid, 0);
    chk("R4 N=0 not reached", sts[0], 0);

    // R4: 256 total deliveries with thresh 0 (DEPTH already counted)
    cyc(1);
    for (int i = 0; i < 255 - DEPTH; i++) send(1);
    cyc(3); @(negedge clk);
    chk("R4 255 of 256", sts[0], 0);
    send(1); cyc(2); @(negedge clk);
    chk("R4 256 reached", sts[0], 1);
    chk("R1 reserved zero", sts & 8'hFA, 0);

    cyc(2);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule